// File: doc/BRIEF.md
# CAN FD Data-Phase Bit Timing Generator

This block produces the bit timing for the fast data phase of a CAN FD controller. A 32-bit configuration word sets five values: the clock prescaler, the lengths of the segments before and after the sample point, the resynchronization jump width, and a flag that enables transceiver delay compensation. Each numeric field is stored as its value minus one. The word can be changed only while the controller holds both its configuration-change enable and its initialization input high. Writes at any other time are dropped.

The module clock is divided into time quanta. Each bit has a sync quantum, then segment one, then segment two. The block raises a one-cycle strobe on the last clock of segment one, which is the sample point. It raises a second one-cycle strobe on the last clock of segment two, which is the end of the bit. A falling edge on the receive line while the bus is idle restarts the bit. A falling edge during a bit moves the sample point to follow the transmitter, within the jump width.

Top module: `fd_bit_timer`

## Requirements
- R1: A write with `cfg_we_i` high is accepted only when `cfg_unlock_i` and `init_i` are both high in the same cycle. Any other write leaves `cfg_rdata_o` unchanged.
- R2: After reset `cfg_rdata_o` reads 0x00000A33 and `tdc_en_o` is 0. With this value a bit lasts 16 quanta of one clock each. Counting cycles from the first clock edge after reset release (cycle 0 comes before that edge), `sample_o` pulses in cycles 11 and 27 and `bit_end_o` pulses in cycles 15 and 31.
- R3: The field layout of the word is: bit 23 is the delay-compensation enable (driven on `tdc_en_o`), bits 20:16 are the prescaler, bits 12:8 are segment one, bits 7:4 are segment two and bits 3:0 are the jump width. All other bits read as 0.
- R4: One quantum lasts (prescaler + 1) clock cycles. Each strobe falls on the last clock of a quantum.
- R5: A bit is 1 sync quantum, then (segment-one field + 1) quanta, then (segment-two field + 1) quanta. A bit that starts in cycle s has `sample_o` at s + (2 + seg1)(brp + 1) − 1 and `bit_end_o` at s + (3 + seg1 + seg2)(brp + 1) − 1. There is exactly one sample strobe per bit, and the two strobes never coincide.
- R6: Hard sync: if `rx_i` is 1 in one cycle and 0 in the next, and `bus_idle_i` is high in that second cycle, a new bit starts in the cycle that follows. No strobe is raised in the edge cycle or in the cycle after it.
- R7: Segment-one resync: a falling edge with `bus_idle_i` low, seen in quantum k (1-based) of segment one, lengthens segment one by min(k, jump width + 1) quanta.
- R8: Segment-two resync: a falling edge with `bus_idle_i` low, seen while e quanta of segment two remain after the current one, shortens segment two by min(e, jump width + 1) quanta. If the result is already reached, the bit ends at the end of the current quantum.
- R9: A falling edge inside the sync quantum changes nothing. After one resync, further edges have no effect until the next sample strobe.
- R10: The longest bit, 1 + 32 + 16 = 49 quanta, is timed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_unlock_i | input | 1 | Configuration-change enable |
| init_i | input | 1 | Controller initialization state |
| bus_idle_i | input | 1 | Bus idle: a falling edge is treated as a hard sync |
| rx_i | input | 1 | Receive line, 1 is recessive |
| cfg_rdata_o | output | 32 | Configuration word readback |
| tdc_en_o | output | 1 | Delay-compensation enable flag |
| sample_o | output | 1 | Sample-point strobe |
| bit_end_o | output | 1 | End-of-bit strobe |

## Verification
The assertions assume that `rx_i` and `bus_idle_i` change only between clock edges. They also assume that a configuration change takes effect through a hard sync, never in the middle of a timed bit. The one-sample-per-bit and no-back-to-back-end properties are checked against these assumptions. The stimulus writes the configuration first and then restarts the bit with a hard sync. It drives every edge on `rx_i` one nanosecond after a rising clock edge, and it keeps `bus_idle_i` high only in the cycle of a hard-sync edge. It uses prescaler zero in the resync cases, so that each quantum is one cycle and each edge lands in a known quantum.

// File: rtl/fdbt_pkg.sv
`timescale 1ns/1ps
package fdbt_pkg;
  localparam int CFG_W   = 32;
  localparam int BRP_W   = 5;
  localparam int TS1_W   = 5;
  localparam int TS2_W   = 4;
  localparam int SJW_W   = 4;
  localparam int TDC_POS = 23;
  localparam int BRP_LSB = 16;
  localparam int TS1_LSB = 8;
  localparam int TS2_LSB = 4;
  localparam int SJW_LSB = 0;
  localparam logic [CFG_W-1:0] CFG_RST = 32'h0000_0A33;

  typedef struct packed {
    logic             tdc;
    logic [BRP_W-1:0] brp;
    logic [TS1_W-1:0] ts1;
    logic [TS2_W-1:0] ts2;
    logic [SJW_W-1:0] sjw;
  } cfg_t;

  typedef enum logic [1:0] {SEG_SYNC, SEG_ONE, SEG_TWO} seg_e;

  function automatic cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    cfg_t c;
    c.tdc = w[TDC_POS];
    c.brp = w[BRP_LSB +: BRP_W];
    c.ts1 = w[TS1_LSB +: TS1_W];
    c.ts2 = w[TS2_LSB +: TS2_W];
    c.sjw = w[SJW_LSB +: SJW_W];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] pack_cfg(input cfg_t c);
    logic [CFG_W-1:0] w;
    w = '0;
    w[TDC_POS]            = c.tdc;
    w[BRP_LSB +: BRP_W]   = c.brp;
    w[TS1_LSB +: TS1_W]   = c.ts1;
    w[TS2_LSB +: TS2_W]   = c.ts2;
    w[SJW_LSB +: SJW_W]   = c.sjw;
    return w;
  endfunction
endpackage

// File: rtl/fdbt_cfg_reg.sv
`timescale 1ns/1ps
module fdbt_cfg_reg
  import fdbt_pkg::*;
#(
  parameter int DW = CFG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          unlock_i,
  input  logic          init_i,
  output cfg_t          cfg_o,
  output logic [DW-1:0] rdata_o
);
  cfg_t cfg_q;
  logic wr_ok;

  // both enables must be up for a write to land
  assign wr_ok = we_i & unlock_i & init_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cfg_q <= unpack_cfg(CFG_RST);
    else if (wr_ok) cfg_q <= unpack_cfg(wdata_i);
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = pack_cfg(cfg_q);
endmodule

// File: rtl/fdbt_prescaler.sv
`timescale 1ns/1ps
module fdbt_prescaler #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  // >= keeps a shrunken divider from stalling a count already past it
  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fdbt_seg_ctrl.sv
`timescale 1ns/1ps
module fdbt_seg_ctrl
  import fdbt_pkg::*;
#(
  parameter int S1_W = TS1_W,
  parameter int S2_W = TS2_W,
  parameter int JW_W = SJW_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            hsync_i,
  input  logic            redge_i,
  input  logic [S1_W-1:0] ts1_i,
  input  logic [S2_W-1:0] ts2_i,
  input  logic [JW_W-1:0] sjw_i,
  output logic            sample_o,
  output logic            bit_end_o
);
  localparam int MW    = (S1_W > S2_W) ? ((S1_W > JW_W) ? S1_W : JW_W)
                                       : ((S2_W > JW_W) ? S2_W : JW_W);
  localparam int CNT_W = MW + 1;

  seg_e             seg_q;
  logic [CNT_W-1:0] qc_q, ext_q, shr_q;
  logic             rs_done_q;

  logic [CNT_W-1:0] ts1_e, ts2_e, jw_e;
  logic [CNT_W-1:0] err1, err2, ext_c, shr_c, ext_n, shr_n;
  logic [CNT_W-1:0] s1_last, s2_last;
  logic             in_s1, in_s2, rs_ok, s1_done, s2_done;

  assign ts1_e = CNT_W'(ts1_i);
  assign ts2_e = CNT_W'(ts2_i);
  assign jw_e  = CNT_W'(sjw_i) + 1'b1;

  assign in_s1 = (seg_q == SEG_ONE);
  assign in_s2 = (seg_q == SEG_TWO);
  assign rs_ok = redge_i & ~rs_done_q & (in_s1 | in_s2);

  // late edge: error counts quanta since sync; early edge: quanta left after this one
  assign err1  = qc_q + 1'b1;
  assign err2  = (qc_q >= ts2_e) ? '0 : (ts2_e - qc_q);
  assign ext_c = (err1 < jw_e) ? err1 : jw_e;
  assign shr_c = (err2 < jw_e) ? err2 : jw_e;
  assign ext_n = (rs_ok && in_s1) ? ext_c : ext_q;
  assign shr_n = (rs_ok && in_s2) ? shr_c : shr_q;

  assign s1_last = ts1_e + ext_n;
  assign s2_last = (shr_n > ts2_e) ? '0 : (ts2_e - shr_n);
  assign s1_done = tick_i & in_s1 & (qc_q >= s1_last);
  assign s2_done = tick_i & in_s2 & (qc_q >= s2_last);

  assign sample_o  = s1_done & ~hsync_i;
  assign bit_end_o = s2_done & ~hsync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q     <= SEG_SYNC;
      qc_q      <= '0;
      ext_q     <= '0;
      shr_q     <= '0;
      rs_done_q <= 1'b0;
    end else if (hsync_i) begin
      seg_q     <= SEG_SYNC;
      qc_q      <= '0;
      ext_q     <= '0;
      shr_q     <= '0;
      rs_done_q <= 1'b0;
    end else begin
      ext_q <= ext_n;
      shr_q <= shr_n;
      if (rs_ok) rs_done_q <= 1'b1;
      if (tick_i) begin
        unique case (seg_q)
          SEG_SYNC: begin
            seg_q <= SEG_ONE;
            qc_q  <= '0;
          end
          SEG_ONE: begin
            if (s1_done) begin
              seg_q     <= SEG_TWO;
              qc_q      <= '0;
              ext_q     <= '0;
              rs_done_q <= 1'b0;
            end else begin
              qc_q <= qc_q + 1'b1;
            end
          end
          SEG_TWO: begin
            if (s2_done) begin
              seg_q <= SEG_SYNC;
              qc_q  <= '0;
              shr_q <= '0;
            end else begin
              qc_q <= qc_q + 1'b1;
            end
          end
          default: begin
            seg_q <= SEG_SYNC;
            qc_q  <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/fd_bit_timer.sv
`timescale 1ns/1ps
module fd_bit_timer
  import fdbt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             cfg_unlock_i,
  input  logic             init_i,
  input  logic             bus_idle_i,
  input  logic             rx_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  output logic             tdc_en_o,
  output logic             sample_o,
  output logic             bit_end_o
);
  cfg_t cfg;
  logic rx_q, fall, hsync, redge, tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 1'b1;
    else         rx_q <= rx_i;
  end

  assign fall  = rx_q & ~rx_i;
  assign hsync = fall & bus_idle_i;
  assign redge = fall & ~bus_idle_i;

  fdbt_cfg_reg #(.DW(CFG_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .unlock_i (cfg_unlock_i),
    .init_i   (init_i),
    .cfg_o    (cfg),
    .rdata_o  (cfg_rdata_o)
  );

  fdbt_prescaler #(.W(BRP_W)) u_psc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (hsync),
    .div_i     (cfg.brp),
    .tick_o    (tick)
  );

  fdbt_seg_ctrl #(.S1_W(TS1_W), .S2_W(TS2_W), .JW_W(SJW_W)) u_seg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .hsync_i   (hsync),
    .redge_i   (redge),
    .ts1_i     (cfg.ts1),
    .ts2_i     (cfg.ts2),
    .sjw_i     (cfg.sjw),
    .sample_o  (sample_o),
    .bit_end_o (bit_end_o)
  );

  assign tdc_en_o = cfg.tdc;
endmodule

// File: rtl/fdbt_checker.sv
`timescale 1ns/1ps
module fdbt_checker
  import fdbt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             cfg_unlock_i,
  input logic             init_i,
  input logic [CFG_W-1:0] cfg_rdata_o,
  input logic             sample_o,
  input logic             bit_end_o,
  input logic             hsync_i
);
  localparam logic [CFG_W-1:0] USED = pack_cfg(cfg_t'('1));

  logic [1:0] smp_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   smp_cnt <= '0;
    else if (hsync_i || bit_end_o) smp_cnt <= '0;
    else if (sample_o && smp_cnt != 2'd3) smp_cnt <= smp_cnt + 1'b1;
  end

  p_wr_lock_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !(cfg_unlock_i && init_i)) |=> $stable(cfg_rdata_o));

  p_rsv_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o & ~USED) == '0);

  p_strobe_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && bit_end_o));

  p_one_sample_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_end_o |-> (smp_cnt == 2'd1));

  p_hsync_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_i |=> (!sample_o && !bit_end_o));

  p_end_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_end_o |=> !bit_end_o);
endmodule

bind fd_bit_timer fdbt_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_we_i     (cfg_we_i),
  .cfg_unlock_i (cfg_unlock_i),
  .init_i       (init_i),
  .cfg_rdata_o  (cfg_rdata_o),
  .sample_o     (sample_o),
  .bit_end_o    (bit_end_o),
  .hsync_i      (hsync)
);

// File: tb/fd_bit_timer_test.sv
`timescale 1ns/1ps
module fd_bit_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        unlock = 1'b0;
  logic        init = 1'b0;
  logic        idle = 1'b0;
  logic        rx = 1'b1;
  logic [31:0] rdata;
  logic        tdc_en, sample, bit_end;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  bit kind;

  int    exp_c[$];
  bit    exp_k[$];
  string exp_r[$];

  always #2.5 clk = ~clk;

  fd_bit_timer uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cfg_we_i     (we),
    .cfg_wdata_i  (wdata),
    .cfg_unlock_i (unlock),
    .init_i       (init),
    .bus_idle_i   (idle),
    .rx_i         (rx),
    .cfg_rdata_o  (rdata),
    .tdc_en_o     (tdc_en),
    .sample_o     (sample),
    .bit_end_o    (bit_end)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // monitor: compares every strobe against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      while (exp_c.size() > 0 && exp_c[0] < cyc) begin
        checks++; failures++;
        $display("FAIL %s: missing %s strobe, actual none, expected cycle %0d",
                 exp_r[0], exp_k[0] ? "end" : "sample", exp_c[0]);
        void'(exp_c.pop_front()); void'(exp_k.pop_front()); void'(exp_r.pop_front());
      end
      if (sample || bit_end) begin
        checks++;
        kind = bit_end;
        if (exp_c.size() == 0) begin
          failures++;
          $display("FAIL unexpected: %s strobe at cycle %0d, expected none",
                   kind ? "end" : "sample", cyc);
        end else begin
          if (exp_c[0] != cyc || exp_k[0] != kind) begin
            failures++;
            $display("FAIL %s: actual %s at cycle %0d, expected %s at cycle %0d",
                     exp_r[0], kind ? "end" : "sample", cyc,
                     exp_k[0] ? "end" : "sample", exp_c[0]);
          end
          void'(exp_c.pop_front()); void'(exp_k.pop_front()); void'(exp_r.pop_front());
        end
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s actual 0x%08h expected 0x%08h", req, what, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic at_cycle(input int c);
    forever begin
      step();
      if (cyc == c) break;
    end
  endtask

  // driver: pushes the two strobes of one bit, returns the start of the next
  task automatic push_bit(input int s, input int p, input int t1, input int t2,
                          input string req, output int nxt);
    exp_c.push_back(s + (1 + t1) * (p + 1) - 1);      exp_k.push_back(1'b0); exp_r.push_back(req);
    exp_c.push_back(s + (1 + t1 + t2) * (p + 1) - 1); exp_k.push_back(1'b1); exp_r.push_back(req);
    nxt = s + (1 + t1 + t2) * (p + 1);
  endtask

  task automatic push_one(input int c, input bit k, input string req);
    exp_c.push_back(c); exp_k.push_back(k); exp_r.push_back(req);
  endtask

  task automatic write_cfg(input logic [31:0] d, input bit ul, input bit in);
    step();
    we = 1'b1; wdata = d; unlock = ul; init = in;
    step();
    we = 1'b0; unlock = 1'b0; init = 1'b0;
  endtask

  // falling edge while idle; returns the first cycle of the new bit
  task automatic hard_sync(output int s);
    step();
    idle = 1'b1; rx = 1'b0;
    s = cyc + 1;
    step();
    idle = 1'b0; rx = 1'b1; mon_on = 1'b1;
  endtask

  task automatic edge_at(input int c);
    at_cycle(c);
    rx = 1'b0;
    step();
    rx = 1'b1;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 3000 && exp_c.size() > 0; i++) step();
    step();
    mon_on = 1'b0;
    chk(exp_c.size() == 0, req, "pending strobes", exp_c.size(), 0);
    exp_c.delete(); exp_k.delete(); exp_r.delete();
  endtask

  initial begin
    #(150000 * 5);
    checks++; failures++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int s, n;
    // R2: reset state and free-running default bits
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rdata == 32'h0000_0A33, "R2", "reset word", rdata, 32'h0000_0A33);
    chk(tdc_en == 1'b0, "R2", "reset tdc flag", tdc_en, 0);
    chk(!sample && !bit_end, "R2", "strobes in reset", {sample, bit_end}, 0);
    push_bit(0, 0, 11, 4, "R2", n);
    push_bit(n, 0, 11, 4, "R5", n);
    mon_on = 1'b1;
    rst_n = 1'b1;
    drain("R2");

    // R1: writes with one enable missing are dropped
    write_cfg(32'h00FF_FFFF, 1'b1, 1'b0);
    chk(rdata == 32'h0000_0A33, "R1", "write without init", rdata, 32'h0000_0A33);
    write_cfg(32'h00FF_FFFF, 1'b0, 1'b1);
    chk(rdata == 32'h0000_0A33, "R1", "write without unlock", rdata, 32'h0000_0A33);

    // R3: field layout, reserved bits read zero
    write_cfg(32'hFFFF_FFFF, 1'b1, 1'b1);
    chk(rdata == 32'h009F_1FFF, "R3", "all-ones readback", rdata, 32'h009F_1FFF);
    chk(tdc_en == 1'b1, "R3", "tdc flag", tdc_en, 1);

    // R4/R5/R6: prescaler 2, seg1 3 quanta, seg2 2 quanta
    write_cfg(32'h0002_0210, 1'b1, 1'b1);
    chk(rdata == 32'h0002_0210, "R1", "unlocked write", rdata, 32'h0002_0210);
    chk(tdc_en == 1'b0, "R3", "tdc flag cleared", tdc_en, 0);
    hard_sync(s);
    push_bit(s, 2, 3, 2, "R4", n);
    push_bit(n, 2, 3, 2, "R6", n);
    drain("R4");

    // R10: longest bit, 49 quanta of 2 clocks
    write_cfg(32'h0001_1FF0, 1'b1, 1'b1);
    hard_sync(s);
    push_bit(s, 1, 32, 16, "R10", n);
    drain("R10");

    // resync cases at default timing: sync 1, seg1 11, seg2 4, jump 4
    write_cfg(32'h0000_0A33, 1'b1, 1'b1);

    // R7: edge in seg1 quantum 2 lengthens by 2
    hard_sync(s);
    push_one(s + 13, 1'b0, "R7"); push_one(s + 17, 1'b1, "R7");
    push_bit(s + 18, 0, 11, 4, "R7", n);
    edge_at(s + 2);
    drain("R7");

    // R7: edge in seg1 quantum 7 clamped to jump width 4
    hard_sync(s);
    push_one(s + 15, 1'b0, "R7"); push_one(s + 19, 1'b1, "R7");
    edge_at(s + 7);
    drain("R7");

    // R8: edge in seg2 with 2 quanta left ends bit at once
    hard_sync(s);
    push_one(s + 11, 1'b0, "R8"); push_one(s + 13, 1'b1, "R8");
    push_bit(s + 14, 0, 11, 4, "R8", n);
    edge_at(s + 13);
    drain("R8");

    // R9: edge in the sync quantum of the second bit changes nothing
    hard_sync(s);
    push_bit(s, 0, 11, 4, "R9", n);
    push_bit(n, 0, 11, 4, "R9", n);
    edge_at(s + 16);
    drain("R9");

    // R9: second edge before the sample point is ignored
    hard_sync(s);
    push_one(s + 13, 1'b0, "R9"); push_one(s + 17, 1'b1, "R9");
    edge_at(s + 2);
    edge_at(s + 5);
    drain("R9");

    // R8: jump width 1 limits the shortening
    write_cfg(32'h0000_0A30, 1'b1, 1'b1);
    chk(rdata == 32'h0000_0A30, "R8", "jump width 1 word", rdata, 32'h0000_0A30);
    hard_sync(s);
    push_one(s + 11, 1'b0, "R8"); push_one(s + 14, 1'b1, "R8");
    push_bit(s + 15, 0, 11, 4, "R8", n);
    edge_at(s + 13);
    drain("R8");

    summary();
    $finish;
  end
endmodule